// File: doc/BRIEF.md
# Data EEPROM Control Register Unit

This block sits between a processor's register bus and a small byte-wide nonvolatile data store. It holds its own array, which is 256 bytes by default. Software sees four 8-bit registers. The address register picks a location. The data register holds the byte to be stored, or the byte just fetched. The control and status register holds the command, enable and error bits. The key register has no storage and exists only to unlock writes. A read takes one clock. A write is timed over a parameterised number of clocks and raises a completion interrupt flag. That flag stays set until software clears it.

The block has two resets. Power-on reset clears everything. Warm reset comes from an external pin or a watchdog. It clears the working registers but keeps the interrupt flag, and it keeps the error flag. If a warm reset cuts a write short, it sets the error flag and the target byte keeps its old value. Software can then see that the write failed and repeat it.

Top module: `nvdata_ctrl`

## Requirements
- R1: The register select `reg_addr` maps 0 to control, 1 to key, 2 to data and 3 to address. In the control register, bit 0 is the read command, bit 1 is the write command (busy), bit 2 is write-enable and bit 3 is the error flag. Bits 7..4 always read 0, whatever is written to them.
- R2: Software can only set the two command bits. Writing 0 to either one leaves it unchanged.
- R3: Setting the read command loads the data register with the byte at the address register on the next clock edge. The read command clears on that same edge.
- R4: Setting the write command starts a write only when write-enable already reads 1 and key-register writes of 0x55 then 0xAA were the latest two since the previous write start. Otherwise the request is dropped. Each write start uses up the unlock.
- R5: A started write holds the write bit at 1 for exactly WRITE_CYCLES clocks. On the last of these clocks the array byte is updated, the write bit clears and `done_irq` rises.
- R6: While a write is busy, software writes to the control, data and address registers are ignored. The one exception is clearing write-enable. The write stores the address and data that were in place at its start.
- R7: A warm reset while a write is busy sets the error flag and leaves the target byte unchanged. A warm reset with no write busy leaves the error flag as it was. A warm reset never clears `done_irq`.
- R8: Either reset clears the data register, the address register, both command bits, write-enable and the unlock progress.
- R9: Power-on reset clears the error flag and `done_irq`. Software may write the error flag while no write is busy.
- R10: The key register always reads 0. `reg_rdata` is 0 whenever `reg_rd` is low.
- R11: `done_irq` stays set until a cycle with `irq_clr` high. If a completion happens in the same cycle, the completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst_n | input | 1 | Warm reset (pin or watchdog), active low, synchronous |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq_clr | input | 1 | Software clear of the completion flag |
| done_irq | output | 1 | Write-complete interrupt flag |

## Verification
A fault in the unlock tracker shows up in one of two ways. Either a write starts when it should not, and the write bit reads 1 right after the control write, or a write never starts and `done_irq` stays low past WRITE_CYCLES. A fault in the write timer moves the clock on which the write bit falls and `done_irq` rises, so it shows at exactly cycle WRITE_CYCLES. A write-back that is gated wrongly during an abort only shows later, when the byte is read back, so every abort is followed by a one-cycle read of the target location.

// File: rtl/nvd_pkg.sv
package nvd_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_ADDR = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2
  } key_state_e;

  localparam int B_RD   = 0;
  localparam int B_WR   = 1;
  localparam int B_WREN = 2;
  localparam int B_ERR  = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // Next unlock state after one write to the key register.
  function automatic key_state_e key_next(key_state_e cur, logic [7:0] d);
    if (d == KEY_FIRST) return KEY_HALF;
    if (d == KEY_SECOND && cur == KEY_HALF) return KEY_ARMED;
    return KEY_IDLE;
  endfunction

  // Software view of the control register; upper nibble is never backed.
  function automatic logic [7:0] ctrl_view(logic rd, logic wr, logic wren, logic err);
    return {4'b0000, err, wren, wr, rd};
  endfunction

endpackage

// File: rtl/nvd_unlock.sv
module nvd_unlock
  import nvd_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  input  logic       consume,
  output logic       armed
);

  key_state_e st_q;

  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) st_q <= KEY_IDLE;
    else if (consume)          st_q <= KEY_IDLE;
    else if (key_we)           st_q <= key_next(st_q, key_data);
  end

  assign armed = (st_q == KEY_ARMED);

  // R4: entering the armed state requires a key write of the second byte
  p_arm_needs_second_r4: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    (armed && !$past(armed)) |-> ($past(key_we) && $past(key_data) == KEY_SECOND));

  // R8: unlock progress never survives a reset
  p_reset_disarms_r8: assert property (@(posedge clk)
    disable iff (!por_n)
    !warm_rst_n |=> !armed);

endmodule

// File: rtl/nvd_write_seq.sv
module nvd_write_seq #(
  parameter int WRITE_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic abort
);

  localparam int CW = (WRITE_CYCLES < 2) ? 1 : $clog2(WRITE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // completion is only real when no reset is cutting the write
  assign done  = busy && (cnt_q == LAST) && por_n && warm_rst_n;
  assign abort = busy && por_n && !warm_rst_n;

  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the count never passes the last write cycle
  p_cnt_bound_r5: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    busy |-> (cnt_q <= LAST));

  // R5: completion ends the busy period
  p_done_ends_r5: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    done |=> !busy);

  // R6: no new start while one is running
  p_start_idle_r6: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    start |-> !busy);

endmodule

// File: rtl/nvd_array.sv
module nvd_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/nvdata_ctrl.sv
module nvdata_ctrl
  import nvd_pkg::*;
#(
  parameter int WRITE_CYCLES = 16,
  parameter int ADDR_W       = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       warm_rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_clr,
  output logic       done_irq
);

  logic              rd_q, wren_q, err_q, irq_q;
  logic [7:0]        data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        cell_rd;
  logic              busy, done, abort, armed;

  // decoded register events
  logic wr_ctrl, wr_key, wr_data, wr_addr;
  logic start, read_req;

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_key  = reg_wr && (reg_addr == SEL_KEY);
  assign wr_data = reg_wr && (reg_addr == SEL_DATA);
  assign wr_addr = reg_wr && (reg_addr == SEL_ADDR);

  assign start    = wr_ctrl && reg_wdata[B_WR] && !busy && wren_q && armed;
  assign read_req = wr_ctrl && reg_wdata[B_RD] && !busy && !rd_q;

  nvd_unlock u_unlock (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .key_we     (wr_key),
    .key_data   (reg_wdata),
    .consume    (start),
    .armed      (armed)
  );

  nvd_write_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .abort      (abort)
  );

  nvd_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk   (clk),
    .we    (done),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (addr_q),
    .rdata (cell_rd)
  );

  // read command: set by software, cleared by hardware one edge later
  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) rd_q <= 1'b0;
    else if (rd_q)             rd_q <= 1'b0;
    else if (read_req)         rd_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) data_q <= '0;
    else if (rd_q)             data_q <= cell_rd;
    else if (wr_data && !busy) data_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) addr_q <= '0;
    else if (wr_addr && !busy) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  // write-enable: only clearing is honoured during a busy write
  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) wren_q <= 1'b0;
    else if (wr_ctrl) begin
      if (!busy)                  wren_q <= reg_wdata[B_WREN];
      else if (!reg_wdata[B_WREN]) wren_q <= 1'b0;
    end
  end

  // error flag: cleared by power-on only, set by an aborted write
  always_ff @(posedge clk) begin
    if (!por_n)                err_q <= 1'b0;
    else if (!warm_rst_n) begin
      if (abort)               err_q <= 1'b1;
    end
    else if (wr_ctrl && !busy) err_q <= reg_wdata[B_ERR];
  end

  always_ff @(posedge clk) begin
    if (!por_n)       irq_q <= 1'b0;
    else if (done)    irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  assign done_irq = irq_q;

  logic [7:0] addr_view;
  always_comb begin
    addr_view = '0;
    addr_view[ADDR_W-1:0] = addr_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        SEL_CTRL: reg_rdata = ctrl_view(rd_q, busy, wren_q, err_q);
        SEL_KEY:  reg_rdata = '0;
        SEL_DATA: reg_rdata = data_q;
        SEL_ADDR: reg_rdata = addr_view;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R1: upper control bits never read as 1
  p_upper_zero_r1: assert property (@(posedge clk)
    (reg_rd && reg_addr == SEL_CTRL) |-> (reg_rdata[7:4] == 4'b0000));

  // R10: the key register has no storage
  p_key_reads_zero_r10: assert property (@(posedge clk)
    (reg_rd && reg_addr == SEL_KEY) |-> (reg_rdata == 8'h00));

  // R3: a read command lives for exactly one cycle
  p_read_one_cycle_r3: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    rd_q |=> !rd_q);

  // R4: a write only begins with enable and unlock in place
  p_start_gated_r4: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    $rose(busy) |-> ($past(wren_q) && $past(armed)));

  // R6: the target address is frozen for the whole write
  p_addr_locked_r6: assert property (@(posedge clk)
    disable iff (!por_n || !warm_rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

  // R7: an aborted write leaves the error flag set
  p_abort_flags_r7: assert property (@(posedge clk)
    disable iff (!por_n)
    abort |=> err_q);

  // R11: the completion flag holds until software clears it
  p_irq_hold_r11: assert property (@(posedge clk)
    disable iff (!por_n)
    (irq_q && !irq_clr) |=> irq_q);

  // R8: warm reset empties the working registers
  p_warm_clears_r8: assert property (@(posedge clk)
    disable iff (!por_n)
    !warm_rst_n |=> (data_q == 8'h00 && addr_q == '0 && !busy && !wren_q));

endmodule

// File: tb/sim_nvdata_ctrl.sv
module sim_nvdata_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 16;

  logic       clk;
  logic       por_n, warm_rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_clr;
  logic       done_irq;

  int n_cmp = 0;
  int n_bad = 0;

  nvdata_ctrl #(.WRITE_CYCLES(WCYC), .ADDR_W(8)) u0 (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_clr    (irq_clr),
    .done_irq   (done_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    reg_rd = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic unlock();
    wr_reg(2'd1, 8'h55);
    wr_reg(2'd1, 8'hAA);
  endtask

  task automatic start_write(input logic [7:0] a, input logic [7:0] d);
    wr_reg(2'd3, a);
    wr_reg(2'd2, d);
    wr_reg(2'd0, 8'h04);
    unlock();
    wr_reg(2'd0, 8'h06);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic mem_read(input logic [7:0] a, output logic [7:0] v);
    wr_reg(2'd3, a);
    wr_reg(2'd0, 8'h01);
    @(negedge clk);
    rd_reg(2'd2, v);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [7:0] d);
    start_write(a, d);
    repeat (WCYC + 1) @(negedge clk);
    clear_irq();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); check("R8", "ctrl after power-on", v, 8'h00);
    rd_reg(2'd2, v); check("R8", "data after power-on", v, 8'h00);
    rd_reg(2'd3, v); check("R8", "addr after power-on", v, 8'h00);
    check("R9", "irq after power-on", {7'b0, done_irq}, 8'h00);
  endtask

  task automatic t_basic_write();
    logic [7:0] v;
    start_write(8'h10, 8'h3C);
    rd_reg(2'd0, v); check("R5", "write bit right after start", v, 8'h06);
    repeat (WCYC - 1) @(negedge clk);
    rd_reg(2'd0, v); check("R5", "write bit on last busy cycle", v, 8'h06);
    check("R5", "irq before completion", {7'b0, done_irq}, 8'h00);
    @(negedge clk);
    rd_reg(2'd0, v); check("R5", "write bit after completion", v, 8'h04);
    check("R5", "irq after completion", {7'b0, done_irq}, 8'h01);
    repeat (4) @(negedge clk);
    check("R11", "irq held without clear", {7'b0, done_irq}, 8'h01);
    clear_irq();
    check("R11", "irq after clear", {7'b0, done_irq}, 8'h00);
    // one-cycle read
    wr_reg(2'd3, 8'h10);
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd0, v); check("R3", "read bit set", v, 8'h01);
    @(negedge clk);
    rd_reg(2'd0, v); check("R3", "read bit cleared by hardware", v, 8'h00);
    rd_reg(2'd2, v); check("R3", "data after read", v, 8'h3C);
    full_write(8'hFF, 8'hA5);
    full_write(8'h00, 8'h5A);
    mem_read(8'hFF, v); check("R5", "top location", v, 8'hA5);
    mem_read(8'h00, v); check("R5", "bottom location", v, 8'h5A);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    wr_reg(2'd3, 8'h10);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, v); check("R1", "ctrl after writing all ones", v, 8'h0D);
    @(negedge clk);
    rd_reg(2'd0, v); check("R1", "ctrl one cycle later", v, 8'h0C);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v); check("R9", "error flag cleared by software", v, 8'h00);
    wr_reg(2'd1, 8'h55);
    rd_reg(2'd1, v); check("R10", "key register read", v, 8'h00);
    reg_addr = 2'd2; #1;
    check("R10", "rdata without read strobe", reg_rdata, 8'h00);
    reg_addr = 2'd0;
  endtask

  task automatic t_guard();
    logic [7:0] v;
    full_write(8'h20, 8'h77);
    wr_reg(2'd3, 8'h20);
    wr_reg(2'd2, 8'h11);
    wr_reg(2'd0, 8'h00);
    unlock();
    wr_reg(2'd0, 8'h02);
    rd_reg(2'd0, v); check("R4", "no start without enable", v, 8'h00);
    wr_reg(2'd1, 8'hAA);
    wr_reg(2'd1, 8'h55);
    wr_reg(2'd0, 8'h04);
    wr_reg(2'd0, 8'h06);
    rd_reg(2'd0, v); check("R4", "no start with reversed key", v, 8'h04);
    repeat (WCYC + 2) @(negedge clk);
    check("R4", "no irq from dropped requests", {7'b0, done_irq}, 8'h00);
    mem_read(8'h20, v); check("R4", "location kept", v, 8'h77);
    // one unlock, one start
    wr_reg(2'd2, 8'h11);
    wr_reg(2'd0, 8'h04);
    unlock();
    wr_reg(2'd0, 8'h06);
    repeat (WCYC + 1) @(negedge clk);
    clear_irq();
    wr_reg(2'd0, 8'h06);
    rd_reg(2'd0, v); check("R4", "unlock used up by previous start", v, 8'h04);
    mem_read(8'h20, v); check("R4", "unlocked write stored", v, 8'h11);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    full_write(8'h31, 8'h13);
    start_write(8'h30, 8'hC3);
    wr_reg(2'd3, 8'h31);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h08);
    rd_reg(2'd0, v); check("R2", "write bit survives a 0, enable clears", v, 8'h02);
    rd_reg(2'd3, v); check("R6", "addr locked", v, 8'h30);
    rd_reg(2'd2, v); check("R6", "data locked", v, 8'hC3);
    repeat (WCYC) @(negedge clk);
    check("R6", "irq after locked write", {7'b0, done_irq}, 8'h01);
    clear_irq();
    mem_read(8'h30, v); check("R6", "write used start address", v, 8'hC3);
    mem_read(8'h31, v); check("R6", "other location untouched", v, 8'h13);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    rd_reg(2'd0, v); check("R7", "idle warm reset sets no error", v, 8'h00);
    start_write(8'h40, 8'h9A);
    repeat (WCYC + 1) @(negedge clk);
    // done_irq left set on purpose
    start_write(8'h40, 8'h65);
    repeat (3) @(negedge clk);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
    rd_reg(2'd0, v); check("R7", "error after aborted write", v, 8'h08);
    rd_reg(2'd2, v); check("R8", "data cleared by warm reset", v, 8'h00);
    rd_reg(2'd3, v); check("R8", "addr cleared by warm reset", v, 8'h00);
    check("R7", "irq survives warm reset", {7'b0, done_irq}, 8'h01);
    clear_irq();
    repeat (WCYC + 2) @(negedge clk);
    check("R7", "no completion after abort", {7'b0, done_irq}, 8'h00);
    rd_reg(2'd0, v); check("R7", "error still set later", v, 8'h08);
    mem_read(8'h40, v); check("R7", "aborted location kept old byte", v, 8'h9A);
  endtask

  task automatic t_por();
    logic [7:0] v;
    full_write(8'h50, 8'h01);
    start_write(8'h51, 8'h02);
    repeat (WCYC + 1) @(negedge clk);
    wr_reg(2'd0, 8'h0C);
    rd_reg(2'd0, v); check("R9", "error and enable before power-on", v, 8'h0C);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    rd_reg(2'd0, v); check("R9", "ctrl after power-on reset", v, 8'h00);
    check("R9", "irq after power-on reset", {7'b0, done_irq}, 8'h00);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por_n = 1'b0; warm_rst_n = 1'b1;
    reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_basic_write();
    t_ctrl_bits();
    t_guard();
    t_lock();
    t_abort();
    t_por();
    finish_run();
  end

endmodule